// File: doc/BRIEF.md
# Main Instruction Decoder for a Five-Stage 32-bit RISC Core

This block turns a 32-bit instruction word into the control bundle that steers the rest of the datapath. It has no clock. The decode stage of a pipelined core places it between the fetch register and the register-file read.

Each 6-bit major opcode is sorted into one of six classes:

- register-register
- control flow
- immediate ALU
- load
- store
- not implemented

The class determines the flag set. The opcode's low bits then choose the ALU operation and, for memory instructions, the access size.

The block also produces two datapath values that depend only on the instruction. One is the write-back register index, which picks between the two register fields. The other is the sign-extended 16-bit immediate. Any opcode that is not implemented yields an all-inactive control word, so later stages treat it as a bubble.

Top module: `insn_ctrl_decoder`

Bit fields used throughout: opcode = instr[31:26], rt = instr[20:16], rd = instr[15:11], funct = instr[5:0], immediate = instr[15:0].

ALU codes follow the funct numbering:

| Operation | Code |
|-----------|------|
| SLL (default) | 0 |
| ADD | 32 |
| ADDU | 33 |
| AND | 36 |
| OR | 37 |
| XOR | 38 |
| SLT | 42 |
| SLTU | 43 |

Access-size codes:

| Size | Code |
|------|------|
| none | 0 |
| byte | 1 |
| halfword | 2 |
| word | 3 |
| byte-unsigned | 4 |
| halfword-unsigned | 5 |

## Requirements
- R1: Opcode 0 sets supported, dst_rd and reg_we. It clears mem_rd, mem_wr and alu_imm, sets alu_op to the funct field, and sets the access size to none (0).
- R2: Opcodes 1, 2, 4, 5, 6 and 7 set only supported. alu_op is 0 and the access size is none.
- R3: Opcodes 8 to 14 set supported, alu_imm and reg_we. alu_op is, in opcode order, ADD 32, ADDU 33, SLT 42, SLTU 43, AND 36, OR 37, XOR 38. The access size is none.
- R4: Load opcodes 32, 33, 35, 36 and 37 set supported, alu_imm, reg_we and mem_rd, with alu_op 32. Their access sizes are byte 1, halfword 2, word 3, byte-unsigned 4 and halfword-unsigned 5, in that order.
- R5: Store opcodes 40, 41 and 43 set supported, alu_imm and mem_wr, clear reg_we, and use alu_op 32. Their access sizes are byte 1, halfword 2 and word 3.
- R6: Every other opcode (3, 15 to 31, 34, 38, 39, 42, 44 to 63) clears all six flags and gives alu_op 0 and access size 0.
- R7: wb_idx equals rd when dst_rd is 1 and rt when dst_rd is 0.
- R8: imm_ext equals instr[15:0] sign-extended to 32 bits, for every opcode.
- R9: For any non-zero opcode, the funct field has no effect on any control output.
- R10: mem_rd and mem_wr are never both 1. mem_wr never comes with reg_we. The access size is non-zero exactly when mem_rd or mem_wr is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| instr_i | input | 32 | Instruction word being decoded |
| supported_o | output | 1 | Opcode is implemented |
| mem_rd_o | output | 1 | Instruction reads data memory |
| mem_wr_o | output | 1 | Instruction writes data memory |
| alu_imm_o | output | 1 | Second ALU operand is the extended immediate |
| dst_rd_o | output | 1 | Destination register is rd rather than rt |
| reg_we_o | output | 1 | Result is written back to the register file |
| alu_op_o | output | 6 | ALU operation code |
| acc_size_o | output | 3 | Memory access-size code |
| wb_idx_o | output | 5 | Selected write-back register index |
| imm_ext_o | output | 32 | Sign-extended immediate |

## Verification
The in-line checks assume the instruction word is fully known. Each check is guarded so that it stays quiet while instr_i still carries unknown bits. The bench only ever applies defined words and changes them half a clock period away from the sampling point.

Stimulus reaches every one of the 64 opcodes. For selected opcodes it varies the funct, register and immediate fields independently. This exercises the invariants on flag exclusivity and operand selection under every class without leaving the input space the checks expect.

// File: rtl/icd_pkg.sv
package icd_pkg;

  localparam int OPC_W   = 6;
  localparam int ALUOP_W = 6;
  localparam int NUM_OPC = 1 << OPC_W;

  typedef enum logic [2:0] {
    SZ_NONE   = 3'd0,
    SZ_BYTE   = 3'd1,
    SZ_HALF   = 3'd2,
    SZ_WORD   = 3'd3,
    SZ_BYTE_U = 3'd4,
    SZ_HALF_U = 3'd5
  } acc_size_e;

  typedef enum logic [2:0] {
    CLS_NONE  = 3'd0,
    CLS_REG   = 3'd1,
    CLS_FLOW  = 3'd2,
    CLS_IMM   = 3'd3,
    CLS_LOAD  = 3'd4,
    CLS_STORE = 3'd5
  } op_class_e;

  localparam logic [ALUOP_W-1:0] ALU_SLL  = 6'd0;
  localparam logic [ALUOP_W-1:0] ALU_ADD  = 6'd32;
  localparam logic [ALUOP_W-1:0] ALU_ADDU = 6'd33;
  localparam logic [ALUOP_W-1:0] ALU_AND  = 6'd36;
  localparam logic [ALUOP_W-1:0] ALU_OR   = 6'd37;
  localparam logic [ALUOP_W-1:0] ALU_XOR  = 6'd38;
  localparam logic [ALUOP_W-1:0] ALU_SLT  = 6'd42;
  localparam logic [ALUOP_W-1:0] ALU_SLTU = 6'd43;

  typedef struct packed {
    logic                sup;
    logic                mrd;
    logic                mwr;
    logic                aimm;
    logic                drd;
    logic                we;
    logic [ALUOP_W-1:0]  alu;
    acc_size_e           sz;
  } ctrl_t;

  // Sort a major opcode into its decode class.
  function automatic op_class_e classify(input logic [OPC_W-1:0] opc);
    op_class_e c;
    case (opc)
      6'd0:                               c = CLS_REG;
      6'd1, 6'd2, 6'd4, 6'd5, 6'd6, 6'd7: c = CLS_FLOW;
      6'd8, 6'd9, 6'd10, 6'd11,
      6'd12, 6'd13, 6'd14:                c = CLS_IMM;
      6'd32, 6'd33, 6'd35, 6'd36, 6'd37:  c = CLS_LOAD;
      6'd40, 6'd41, 6'd43:                c = CLS_STORE;
      default:                            c = CLS_NONE;
    endcase
    return c;
  endfunction

  // Low three opcode bits pick the width for both loads and stores.
  function automatic acc_size_e size_of(input logic [2:0] lo);
    acc_size_e s;
    case (lo)
      3'd0:    s = SZ_BYTE;
      3'd1:    s = SZ_HALF;
      3'd3:    s = SZ_WORD;
      3'd4:    s = SZ_BYTE_U;
      3'd5:    s = SZ_HALF_U;
      default: s = SZ_NONE;
    endcase
    return s;
  endfunction

  // Low three opcode bits pick the operation for immediate ALU forms.
  function automatic logic [ALUOP_W-1:0] imm_alu(input logic [2:0] lo);
    logic [ALUOP_W-1:0] a;
    case (lo)
      3'd0:    a = ALU_ADD;
      3'd1:    a = ALU_ADDU;
      3'd2:    a = ALU_SLT;
      3'd3:    a = ALU_SLTU;
      3'd4:    a = ALU_AND;
      3'd5:    a = ALU_OR;
      3'd6:    a = ALU_XOR;
      default: a = ALU_SLL;
    endcase
    return a;
  endfunction

endpackage

// File: rtl/icd_class_map.sv
module icd_class_map
  import icd_pkg::*;
#(
  parameter int OPC_BITS = OPC_W
) (
  input  logic [OPC_BITS-1:0] opcode_i,
  output op_class_e           cls_o,
  output logic                is_reg_o,
  output logic                is_flow_o,
  output logic                is_imm_o,
  output logic                is_load_o,
  output logic                is_store_o
);

  localparam int ENTRIES = 1 << OPC_BITS;

  op_class_e cls_tab [ENTRIES];

  for (genvar g = 0; g < ENTRIES; g++) begin : g_entry
    assign cls_tab[g] = classify(OPC_W'(g));
  end

  assign cls_o      = cls_tab[opcode_i];
  assign is_reg_o   = (cls_o == CLS_REG);
  assign is_flow_o  = (cls_o == CLS_FLOW);
  assign is_imm_o   = (cls_o == CLS_IMM);
  assign is_load_o  = (cls_o == CLS_LOAD);
  assign is_store_o = (cls_o == CLS_STORE);

  always_comb begin
    if (!$isunknown(opcode_i)) begin
      // R4 / R5: memory classes live in the upper half of the opcode space
      p_mem_upper_r4: assert (!(is_load_o || is_store_o) || opcode_i[OPC_BITS-1])
        else $error("memory class outside upper opcode half");
      // R1: only opcode zero is register-register
      p_reg_zero_r1: assert (is_reg_o == (opcode_i == '0))
        else $error("register class mismatch");
    end
  end

endmodule

// File: rtl/icd_ctrl_gen.sv
module icd_ctrl_gen
  import icd_pkg::*;
(
  input  op_class_e          cls_i,
  input  logic [OPC_W-1:0]   opcode_i,
  input  logic [ALUOP_W-1:0] funct_i,
  output ctrl_t              ctrl_o
);

  always_comb begin
    ctrl_o     = '0;
    ctrl_o.alu = ALU_SLL;
    ctrl_o.sz  = SZ_NONE;
    unique case (cls_i)
      CLS_REG: begin
        ctrl_o.sup = 1'b1;
        ctrl_o.drd = 1'b1;
        ctrl_o.we  = 1'b1;
        ctrl_o.alu = funct_i;
      end
      CLS_FLOW: begin
        ctrl_o.sup = 1'b1;
      end
      CLS_IMM: begin
        ctrl_o.sup  = 1'b1;
        ctrl_o.aimm = 1'b1;
        ctrl_o.we   = 1'b1;
        ctrl_o.alu  = imm_alu(opcode_i[2:0]);
      end
      CLS_LOAD: begin
        ctrl_o.sup  = 1'b1;
        ctrl_o.aimm = 1'b1;
        ctrl_o.we   = 1'b1;
        ctrl_o.mrd  = 1'b1;
        ctrl_o.alu  = ALU_ADD;
        ctrl_o.sz   = size_of(opcode_i[2:0]);
      end
      CLS_STORE: begin
        ctrl_o.sup  = 1'b1;
        ctrl_o.aimm = 1'b1;
        ctrl_o.mwr  = 1'b1;
        ctrl_o.alu  = ALU_ADD;
        ctrl_o.sz   = size_of(opcode_i[2:0]);
      end
      default: ;
    endcase
  end

  always_comb begin
    if (!$isunknown({cls_i, opcode_i, funct_i})) begin
      // R10: a memory instruction always carries a real width
      p_size_mem_r10: assert ((ctrl_o.sz != SZ_NONE) == (ctrl_o.mrd || ctrl_o.mwr))
        else $error("access size disagrees with memory flags");
      // R6: no flag is raised for an opcode that is not supported
      p_idle_when_unsup_r6: assert (ctrl_o.sup ||
                                    (!ctrl_o.mrd && !ctrl_o.mwr && !ctrl_o.aimm &&
                                     !ctrl_o.drd && !ctrl_o.we && ctrl_o.alu == ALU_SLL))
        else $error("flags active on unsupported opcode");
      // R5: stores never use an unsigned width
      p_store_signed_r5: assert (!ctrl_o.mwr ||
                                 (ctrl_o.sz != SZ_BYTE_U && ctrl_o.sz != SZ_HALF_U))
        else $error("store with unsigned width");
    end
  end

endmodule

// File: rtl/icd_field_xtr.sv
module icd_field_xtr #(
  parameter int WORD_W    = 32,
  parameter int IMM_W     = 16,
  parameter int REG_IDX_W = 5
) (
  input  logic [REG_IDX_W-1:0] rt_i,
  input  logic [REG_IDX_W-1:0] rd_i,
  input  logic [IMM_W-1:0]     imm_i,
  input  logic                 dst_rd_i,
  output logic [REG_IDX_W-1:0] wb_idx_o,
  output logic [WORD_W-1:0]    imm_ext_o
);

  localparam int EXT_W = WORD_W - IMM_W;

  function automatic logic [WORD_W-1:0] sext(input logic [IMM_W-1:0] v);
    return {{EXT_W{v[IMM_W-1]}}, v};
  endfunction

  assign wb_idx_o  = dst_rd_i ? rd_i : rt_i;
  assign imm_ext_o = sext(imm_i);

  always_comb begin
    if (!$isunknown(imm_i)) begin
      // R8: upper bits all copy the immediate's sign bit
      p_sign_fill_r8: assert (imm_i[IMM_W-1] ? (&imm_ext_o[WORD_W-1:IMM_W])
                                             : (imm_ext_o[WORD_W-1:IMM_W] == '0))
        else $error("sign fill wrong");
      p_low_copy_r8: assert (imm_ext_o[IMM_W-1:0] == imm_i)
        else $error("immediate low half altered");
    end
  end

endmodule

// File: rtl/insn_ctrl_decoder.sv
module insn_ctrl_decoder
  import icd_pkg::*;
#(
  parameter int WORD_W    = 32,
  parameter int IMM_W     = 16,
  parameter int REG_IDX_W = 5
) (
  input  logic [WORD_W-1:0]    instr_i,
  output logic                 supported_o,
  output logic                 mem_rd_o,
  output logic                 mem_wr_o,
  output logic                 alu_imm_o,
  output logic                 dst_rd_o,
  output logic                 reg_we_o,
  output logic [ALUOP_W-1:0]   alu_op_o,
  output logic [2:0]           acc_size_o,
  output logic [REG_IDX_W-1:0] wb_idx_o,
  output logic [WORD_W-1:0]    imm_ext_o
);

  localparam int OPC_LSB = WORD_W - OPC_W;
  localparam int RT_LSB  = OPC_LSB - 2 * REG_IDX_W;
  localparam int RD_LSB  = RT_LSB - REG_IDX_W;

  logic [OPC_W-1:0]     opcode;
  logic [ALUOP_W-1:0]   funct;
  logic [REG_IDX_W-1:0] rt_f;
  logic [REG_IDX_W-1:0] rd_f;
  op_class_e            cls;
  logic                 is_reg, is_flow, is_imm, is_load, is_store;
  ctrl_t                ctrl;

  assign opcode = instr_i[WORD_W-1:OPC_LSB];
  assign funct  = instr_i[ALUOP_W-1:0];
  assign rt_f   = instr_i[RT_LSB +: REG_IDX_W];
  assign rd_f   = instr_i[RD_LSB +: REG_IDX_W];

  icd_class_map #(.OPC_BITS(OPC_W)) u_class (
    .opcode_i   (opcode),
    .cls_o      (cls),
    .is_reg_o   (is_reg),
    .is_flow_o  (is_flow),
    .is_imm_o   (is_imm),
    .is_load_o  (is_load),
    .is_store_o (is_store)
  );

  icd_ctrl_gen u_ctrl (
    .cls_i    (cls),
    .opcode_i (opcode),
    .funct_i  (funct),
    .ctrl_o   (ctrl)
  );

  icd_field_xtr #(
    .WORD_W    (WORD_W),
    .IMM_W     (IMM_W),
    .REG_IDX_W (REG_IDX_W)
  ) u_fields (
    .rt_i      (rt_f),
    .rd_i      (rd_f),
    .imm_i     (instr_i[IMM_W-1:0]),
    .dst_rd_i  (ctrl.drd),
    .wb_idx_o  (wb_idx_o),
    .imm_ext_o (imm_ext_o)
  );

  assign supported_o = ctrl.sup;
  assign mem_rd_o    = ctrl.mrd;
  assign mem_wr_o    = ctrl.mwr;
  assign alu_imm_o   = ctrl.aimm;
  assign dst_rd_o    = ctrl.drd;
  assign reg_we_o    = ctrl.we;
  assign alu_op_o    = ctrl.alu;
  assign acc_size_o  = ctrl.sz;

  always_comb begin
    if (!$isunknown(instr_i)) begin
      // R10: read and write of data memory are exclusive
      p_rw_excl_r10: assert (!(mem_rd_o && mem_wr_o))
        else $error("read and write together");
      // R10: a store never writes the register file
      p_store_no_we_r10: assert (!(mem_wr_o && reg_we_o))
        else $error("store with register write");
      // R7: write-back index taken from the raw instruction bits
      p_wb_sel_r7: assert (wb_idx_o == (dst_rd_o ? instr_i[15:11] : instr_i[20:16]))
        else $error("write-back index wrong");
      // R1: register-register class forwards funct unchanged
      p_rtype_alu_r1: assert (!is_reg || (alu_op_o == instr_i[5:0] && reg_we_o && dst_rd_o))
        else $error("register class control wrong");
      // R2: flow-control class raises supported alone
      p_flow_only_r2: assert (!is_flow ||
                              (supported_o && !reg_we_o && !mem_rd_o && !mem_wr_o && !alu_imm_o))
        else $error("flow class raised extra flag");
      // R3 / R4: immediate and load classes write back through rt
      p_imm_rt_r3: assert (!(is_imm || is_load) || (alu_imm_o && reg_we_o && !dst_rd_o))
        else $error("immediate or load class control wrong");
      // R5: stores use the immediate address path
      p_store_path_r5: assert (!is_store || (alu_imm_o && mem_wr_o && alu_op_o == ALU_ADD))
        else $error("store class control wrong");
    end
  end

endmodule

// File: tb/insn_ctrl_decoder_bench.sv
module insn_ctrl_decoder_bench;

  logic        clk = 1'b0;
  logic [31:0] instr = 32'h0;
  logic        sup, mrd, mwr, aimm, drd, we;
  logic [5:0]  alu;
  logic [2:0]  sz;
  logic [4:0]  wb;
  logic [31:0] imm_ext;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  insn_ctrl_decoder u_insn_ctrl_decoder (
    .instr_i     (instr),
    .supported_o (sup),
    .mem_rd_o    (mrd),
    .mem_wr_o    (mwr),
    .alu_imm_o   (aimm),
    .dst_rd_o    (drd),
    .reg_we_o    (we),
    .alu_op_o    (alu),
    .acc_size_o  (sz),
    .wb_idx_o    (wb),
    .imm_ext_o   (imm_ext)
  );

  // Packed layout: [14]sup [13]mrd [12]mwr [11]aimm [10]drd [9]we [8:3]alu [2:0]size
  function automatic logic [14:0] ref_ctrl(input logic [5:0] opc, input logic [5:0] fn);
    logic [14:0] r;
    case (opc)
      6'd0:  r = {6'b100011, fn, 3'd0};
      6'd1, 6'd2, 6'd4, 6'd5, 6'd6, 6'd7: r = {6'b100000, 6'd0, 3'd0};
      6'd8:  r = {6'b100101, 6'd32, 3'd0};
      6'd9:  r = {6'b100101, 6'd33, 3'd0};
      6'd10: r = {6'b100101, 6'd42, 3'd0};
      6'd11: r = {6'b100101, 6'd43, 3'd0};
      6'd12: r = {6'b100101, 6'd36, 3'd0};
      6'd13: r = {6'b100101, 6'd37, 3'd0};
      6'd14: r = {6'b100101, 6'd38, 3'd0};
      6'd32: r = {6'b110101, 6'd32, 3'd1};
      6'd33: r = {6'b110101, 6'd32, 3'd2};
      6'd35: r = {6'b110101, 6'd32, 3'd3};
      6'd36: r = {6'b110101, 6'd32, 3'd4};
      6'd37: r = {6'b110101, 6'd32, 3'd5};
      6'd40: r = {6'b101100, 6'd32, 3'd1};
      6'd41: r = {6'b101100, 6'd32, 3'd2};
      6'd43: r = {6'b101100, 6'd32, 3'd3};
      default: r = 15'd0;
    endcase
    return r;
  endfunction

  function automatic logic [31:0] mk(input logic [5:0] opc, input logic [4:0] rt,
                                     input logic [4:0] rd, input logic [5:0] fn);
    return {opc, 5'd7, rt, rd, 5'd0, fn};
  endfunction

  function automatic logic [14:0] act_ctrl();
    return {sup, mrd, mwr, aimm, drd, we, alu, sz};
  endfunction

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic apply(input logic [31:0] w);
    @(negedge clk);
    instr = w;
    #2;
  endtask

  task automatic t_reset_state();
    #2;
    chk("R1", "initial word zero control", {17'd0, act_ctrl()}, {17'd0, ref_ctrl(6'd0, 6'd0)});
    chk("R7", "initial write-back index", {27'd0, wb}, 32'd0);
  endtask

  task automatic t_rtype();
    logic [5:0] fns [4] = '{6'd32, 6'd42, 6'd39, 6'd63};
    for (int i = 0; i < 4; i++) begin
      apply(mk(6'd0, 5'd3, 5'(10 + i), fns[i]));
      chk("R1", "register class control", {17'd0, act_ctrl()}, {17'd0, ref_ctrl(6'd0, fns[i])});
      chk("R7", "rd selected", {27'd0, wb}, 32'(10 + i));
    end
  endtask

  task automatic t_flow();
    logic [5:0] ops [6] = '{6'd1, 6'd2, 6'd4, 6'd5, 6'd6, 6'd7};
    for (int i = 0; i < 6; i++) begin
      apply(mk(ops[i], 5'd9, 5'd17, 6'h2a));
      chk("R2", "flow class control", {17'd0, act_ctrl()}, {17'd0, 6'b100000, 9'd0});
    end
  endtask

  task automatic t_imm();
    logic [5:0] codes [7] = '{6'd32, 6'd33, 6'd42, 6'd43, 6'd36, 6'd37, 6'd38};
    for (int i = 0; i < 7; i++) begin
      apply(mk(6'(8 + i), 5'(20 + i), 5'd2, 6'd5));
      chk("R3", "immediate alu code", {26'd0, alu}, {26'd0, codes[i]});
      chk("R3", "immediate flags", {26'd0, sup, mrd, mwr, aimm, drd, we}, {26'd0, 6'b100101});
      chk("R7", "rt selected", {27'd0, wb}, 32'(20 + i));
    end
  endtask

  task automatic t_loads();
    logic [5:0] ops [5] = '{6'd32, 6'd33, 6'd35, 6'd36, 6'd37};
    logic [2:0] szs [5] = '{3'd1, 3'd2, 3'd3, 3'd4, 3'd5};
    for (int i = 0; i < 5; i++) begin
      apply(mk(ops[i], 5'd21, 5'd30, 6'd0));
      chk("R4", "load size", {29'd0, sz}, {29'd0, szs[i]});
      chk("R4", "load flags and alu", {17'd0, act_ctrl()}, {17'd0, 6'b110101, 6'd32, szs[i]});
    end
  endtask

  task automatic t_stores();
    logic [5:0] ops [3] = '{6'd40, 6'd41, 6'd43};
    for (int i = 0; i < 3; i++) begin
      apply(mk(ops[i], 5'd21, 5'd30, 6'd0));
      chk("R5", "store control", {17'd0, act_ctrl()}, {17'd0, 6'b101100, 6'd32, 3'(i == 2 ? 3 : i + 1)});
      chk("R5", "store no register write", {31'd0, we}, 32'd0);
    end
  endtask

  task automatic t_unsupported();
    logic [5:0] ops [8] = '{6'd3, 6'd15, 6'd34, 6'd38, 6'd39, 6'd42, 6'd46, 6'd63};
    for (int i = 0; i < 8; i++) begin
      apply(mk(ops[i], 5'd31, 5'd31, 6'h3f));
      chk("R6", "unimplemented opcode idle", {17'd0, act_ctrl()}, 32'd0);
    end
  endtask

  task automatic t_sign_ext();
    logic [15:0] imms [5] = '{16'h0000, 16'h7fff, 16'h8000, 16'hffff, 16'h1234};
    for (int i = 0; i < 5; i++) begin
      apply({6'd8, 5'd1, 5'd2, imms[i]});
      chk("R8", "sign extension", imm_ext, {{16{imms[i][15]}}, imms[i]});
      apply({6'd43, 5'd1, 5'd2, imms[i]});
      chk("R8", "sign extension on store", imm_ext, {{16{imms[i][15]}}, imms[i]});
    end
  endtask

  task automatic t_funct_ignored();
    logic [5:0] ops [4] = '{6'd35, 6'd9, 6'd4, 6'd50};
    for (int i = 0; i < 4; i++) begin
      apply(mk(ops[i], 5'd4, 5'd5, 6'd0));
      begin
        logic [14:0] base = act_ctrl();
        apply(mk(ops[i], 5'd4, 5'd5, 6'h3f));
        chk("R9", "funct change ignored", {17'd0, act_ctrl()}, {17'd0, base});
        apply(mk(ops[i], 5'd4, 5'd5, 6'h15));
        chk("R9", "funct change ignored", {17'd0, act_ctrl()}, {17'd0, base});
      end
    end
  endtask

  task automatic t_sweep();
    for (int op = 0; op < 64; op++) begin
      apply(mk(6'(op), 5'(op % 32), 5'((op + 7) % 32), 6'(op ^ 6'h15)));
      chk("R6", "sweep against reference", {17'd0, act_ctrl()},
          {17'd0, ref_ctrl(6'(op), 6'(op ^ 6'h15))});
      chk("R10", "exclusivity and size consistency",
          {29'd0, mrd && mwr, mwr && we, (sz != 3'd0) != (mrd || mwr)}, 32'd0);
      chk("R7", "sweep write-back index", {27'd0, wb},
          {27'd0, drd ? 5'((op + 7) % 32) : 5'(op % 32)});
    end
  endtask

  initial begin
    t_reset_state();
    t_rtype();
    t_flow();
    t_imm();
    t_loads();
    t_stores();
    t_unsupported();
    t_sign_ext();
    t_funct_ignored();
    t_sweep();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule